// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Sixteenth-Bit Stop Control

This block serialises bytes onto an asynchronous line. A clock-enable pulse arrives at sixteen times the bit rate, and every output transition happens only on a clock edge where that pulse is high. A frame is one low start bit, then eight data bits with the least significant bit first, then a high stop interval. Each start and data bit lasts 16 ticks. An idle line is high, so an idle line looks the same as a stop interval.

The stop interval is not a whole number of bits. It is counted in sixteenths of a bit and is picked by a 4-bit length code. A signed trim can then shorten or lengthen it by up to four sixteenths. A relay node that forwards traffic from a slightly faster upstream link uses this to move its next start edge a little earlier. The trim cannot bring the stop interval below 9/16 of a bit, because a far receiver must still see a stop level at its mid-bit sample.

Bytes arrive on a valid/ready handshake. The block accepts a byte while the line is idle, or while the stop interval of the previous frame is running. A byte accepted during a stop interval starts its start bit on the tick that ends that stop interval, so back-to-back frames have no extra gap.

Top module: `uart_frac_tx`

## Requirements
- R1: While reset is asserted and whenever no frame is being sent, `line_out` is high. After reset is released, `tx_ready` is high.
- R2: A frame is a low start bit of 16 ticks, followed by 8 data bits of 16 ticks each, sent bit 0 first. The stop interval follows the last data bit.
- R3: `line_out` changes only on a clock edge at which `tick` is high.
- R4: Length codes 0 to 7 on `stop_code` select a stop interval of 9 + code ticks, which is 9/16 to 16/16 of a bit.
- R5: Length codes 8 to 15 select a stop interval of 17 + code ticks, which is 25/16 to 32/16 of a bit.
- R6: `stop_trim` is a 4-bit two's complement value that is added to the selected stop interval. Values above +4 act as +4, and values below -4 act as -4.
- R7: The stop interval is never shorter than 9 ticks. Any smaller sum of code and trim is raised to 9.
- R8: The length code and the trim are sampled in the cycle the byte is accepted. They apply to the stop interval of that byte's own frame, whatever the inputs do afterwards.
- R9: `tx_ready` is low from the acceptance of a byte until that byte's stop interval begins. It is high during a stop interval and while idle, unless a byte is already waiting.
- R10: A byte accepted during a stop interval drives the line low on the tick that ends that stop interval. The high time between the two frames therefore equals the programmed stop length exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Enable pulse at 16x the bit rate |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` holds a byte to send |
| tx_ready | output | 1 | Block can take a byte this cycle |
| stop_code | input | 4 | Stop length code, sampled when a byte is accepted |
| stop_trim | input | 4 | Signed stop trim in sixteenths, sampled when a byte is accepted |
| line_out | output | 1 | Serial line, high when idle |

## Verification
A wrong tick counter or bit index shows up at once on the line. A data bit sampled at its mid-point holds the wrong value, or the stop level arrives at the wrong tick, within the frame that follows. A wrong stop length, or a length taken from the live inputs instead of the captured ones, shows only as the distance between two falling edges. For this reason, stop lengths are measured with back-to-back frames, where the second byte is waiting and the input code has been changed after the first acceptance. A ready signal that drops or rises at the wrong time shows up as a frame gap that is one or more ticks too long.

// File: rtl/uart_frac_tx.sv
module uart_frac_tx #(
  parameter int DATA_BITS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [DATA_BITS-1:0]    tx_data,
  input  logic                    tx_valid,
  output logic                    tx_ready,
  input  logic [3:0]              stop_code,
  input  logic signed [3:0]       stop_trim,
  output logic                    line_out
);

  localparam int TPB      = 16;
  localparam int TRIM_MAX = 4;
  localparam int STOP_MIN = 9;
  localparam int STOP_MAX = 32 + TRIM_MAX;
  localparam int LEN_W    = $clog2(STOP_MAX + 1);
  localparam int IDX_W    = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [LEN_W-1:0] BIT_LAST = LEN_W'(TPB - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} phase_t;

  phase_t                 phase;
  logic [LEN_W-1:0]       cnt;
  logic [IDX_W-1:0]       bit_idx;
  logic [DATA_BITS-1:0]   shreg;
  logic [LEN_W-1:0]       cur_len;
  logic                   pend;
  logic [DATA_BITS-1:0]   pend_data;
  logic [LEN_W-1:0]       pend_len;

  logic [LEN_W-1:0]       req_len;
  logic                   accept, stop_done, launch;
  logic [DATA_BITS-1:0]   src_data;
  logic [LEN_W-1:0]       src_len;

  always_comb begin
    int base, trim, sum;
    base = stop_code[3] ? 17 + int'(stop_code) : 9 + int'(stop_code);
    trim = int'(stop_trim);
    if (trim > TRIM_MAX)  trim = TRIM_MAX;
    if (trim < -TRIM_MAX) trim = -TRIM_MAX;
    sum = base + trim;
    if (sum < STOP_MIN) sum = STOP_MIN;
    req_len = LEN_W'(sum);
  end

  assign tx_ready  = !pend && (phase == S_IDLE || phase == S_STOP);
  assign accept    = tx_valid && tx_ready;
  assign stop_done = (phase == S_STOP) && (cnt == cur_len - 1'b1);
  assign launch    = tick && (phase == S_IDLE || stop_done) && (pend || accept);
  assign src_data  = pend ? pend_data : tx_data;
  assign src_len   = pend ? pend_len  : req_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= S_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      cur_len   <= LEN_W'(STOP_MIN);
      pend      <= 1'b0;
      pend_data <= '0;
      pend_len  <= LEN_W'(STOP_MIN);
      line_out  <= 1'b1;
    end else begin
      if (accept && !launch) begin
        pend      <= 1'b1;
        pend_data <= tx_data;
        pend_len  <= req_len;
      end else if (launch) begin
        pend <= 1'b0;
      end

      if (launch) begin
        phase    <= S_START;
        cnt      <= '0;
        shreg    <= src_data;
        cur_len  <= src_len;
        line_out <= 1'b0;
      end else if (tick) begin
        case (phase)
          S_START: begin
            if (cnt == BIT_LAST) begin
              phase    <= S_DATA;
              cnt      <= '0;
              bit_idx  <= '0;
              line_out <= shreg[0];
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (cnt == BIT_LAST) begin
              cnt <= '0;
              if (bit_idx == IDX_LAST) begin
                phase    <= S_STOP;
                line_out <= 1'b1;
              end else begin
                bit_idx  <= bit_idx + 1'b1;
                shreg    <= shreg >> 1;
                line_out <= shreg[1];
              end
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (stop_done) begin
              phase <= S_IDLE;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase == S_IDLE |-> line_out);

  p_change_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_out != $past(line_out)) |-> $past(tick));

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_START) |-> !line_out);

  p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_STOP) |-> line_out);

  p_stop_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_STOP) |-> cur_len <= LEN_W'(STOP_MAX));

  p_stop_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_STOP) |-> cur_len >= LEN_W'(STOP_MIN));

  p_ready_midframe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_START || phase == S_DATA) |-> !tx_ready);

  p_accept_drops_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_back_to_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && stop_done && pend) |=> (phase == S_START && !line_out));

endmodule

// File: tb/uart_frac_tx_bench.sv
`timescale 1ns/1ps
module uart_frac_tx_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [3:0] stop_code = '0;
  logic signed [3:0] stop_trim = '0;
  logic line_out;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  int tcount = 0;
  logic tick_q = 1'b0;

  logic [7:0] rx_byte [0:63];
  int fall_t [0:63];
  int nf = 0;
  bit in_frame = 0;
  int t0 = 0;
  int bi = 0;
  logic [7:0] rx_sh = '0;
  logic prev_out = 1'b1;
  bit mon_on = 0;

  uart_frac_tx u_uart_frac_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .stop_code(stop_code), .stop_trim(stop_trim), .line_out(line_out)
  );

  always #4 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      tick = (div == 0);
    end
  end

  always @(posedge clk) begin
    tick_q <= tick;
    if (tick) tcount <= tcount + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (line_out != prev_out)
        check(tick_q == 1'b1, "R3 edge off tick", int'(tick_q), 1);
      if (!in_frame && prev_out && !line_out) begin
        in_frame = 1;
        t0 = tcount;
        bi = 0;
        fall_t[nf] = tcount;
      end else if (in_frame) begin
        if (bi == 0 && tcount == t0 + 8 && rx_sh !== 8'hxx)
          check(line_out == 1'b0, "R2 start bit low", int'(line_out), 0);
        if (bi < 8 && tcount == t0 + 24 + 16 * bi) begin
          rx_sh[bi] = line_out;
          bi++;
        end
        if (bi == 8 && tcount == t0 + 152) begin
          check(line_out == 1'b1, "R2 stop level", int'(line_out), 1);
          rx_byte[nf] = rx_sh;
          nf++;
          in_frame = 0;
        end
      end
    end
    prev_out = line_out;
  end

  function automatic int exp_len(input int code, input int trim);
    int b, t, s;
    b = (code < 8) ? 9 + code : 17 + code;
    t = trim > 4 ? 4 : (trim < -4 ? -4 : trim);
    s = b + t;
    return (s < 9) ? 9 : s;
  endfunction

  task automatic push(input logic [7:0] d, input logic [3:0] c, input logic signed [3:0] tr);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; stop_code = c; stop_trim = tr; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    stop_code = ~c;
    stop_trim = 4'sd7;
    tx_data = ~d;
  endtask

  task automatic wait_frames(input int n);
    while (nf < n) @(negedge clk);
  endtask

  task automatic settle();
    repeat (200) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(line_out == 1'b1, "R1 line high in reset", int'(line_out), 1);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;
    check(line_out == 1'b1, "R1 line high after reset", int'(line_out), 1);
    check(tx_ready == 1'b1, "R1 ready after reset", int'(tx_ready), 1);
  endtask

  task automatic t_idle();
    bit ok = 1;
    repeat (400) begin
      @(negedge clk);
      if (line_out !== 1'b1) ok = 0;
    end
    check(ok, "R1 idle line stays high", int'(ok), 1);
  endtask

  task automatic t_byte(input logic [7:0] d);
    int k = nf;
    push(d, 4'd7, 4'sd0);
    wait_frames(k + 1);
    check(rx_byte[k] == d, "R2 byte LSB first", int'(rx_byte[k]), int'(d));
    settle();
  endtask

  task automatic t_gap(input int code, input int trim, input string req);
    int k = nf;
    int gap, exp;
    exp = exp_len(code, trim);
    push(8'h3C, 4'(code), 4'(trim));
    push(8'hC3, 4'hF, 4'sd4);
    wait_frames(k + 2);
    gap = fall_t[k + 1] - fall_t[k] - 144;
    check(gap == exp, req, gap, exp);
    check(rx_byte[k + 1] == 8'hC3, "R10 second byte intact", int'(rx_byte[k + 1]), 'hC3);
    settle();
  endtask

  task automatic t_ready();
    int k = nf;
    push(8'h96, 4'd0, 4'sd0);
    check(tx_ready == 1'b0, "R9 ready low with byte waiting", int'(tx_ready), 0);
    while (!in_frame) @(negedge clk);
    while (tcount < t0 + 70) @(negedge clk);
    check(tx_ready == 1'b0, "R9 ready low in data bits", int'(tx_ready), 0);
    while (tcount < t0 + 146) @(negedge clk);
    check(tx_ready == 1'b1, "R9 ready high in stop", int'(tx_ready), 1);
    wait_frames(k + 1);
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_byte(8'hA5);
    t_byte(8'h00);
    t_byte(8'hFF);
    t_byte(8'h01);
    t_byte(8'h80);
    t_gap(0, 0, "R4 code 0");
    t_gap(7, 0, "R4 code 7");
    t_gap(3, 0, "R4 code 3");
    t_gap(8, 0, "R5 code 8");
    t_gap(15, 0, "R5 code 15");
    t_gap(7, 4, "R6 trim +4");
    t_gap(15, -4, "R6 trim -4");
    t_gap(8, 7, "R6 trim saturates high");
    t_gap(12, -8, "R6 trim saturates low");
    t_gap(3, -8, "R7 floor from saturated trim");
    t_gap(0, -4, "R7 floor at code 0");
    t_gap(2, -1, "R8 captured code and trim");
    t_gap(9, 2, "R10 back-to-back gap exact");
    t_ready();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule